// File: doc/BRIEF.md
# Fast-Domain Power-Up Sequencer

This block is the fast-clock half of a power controller. It leaves reset in a powered-down state and waits for a power-up request from the slow always-on domain. When the request arrives it brings the chip up through a fixed chain of handshakes. First it releases the life-cycle reset stage. Then it starts non-volatile fuse sensing, initialises the life-cycle controller, turns on the peripheral clocks and pulses strap sampling. Finally it acknowledges the slow domain and releases the system reset stage. Each step waits for the responding block to report that its input matches what the sequencer drives.

Once up, the sequencer idles in an active state. A software low-power request is first checked against the processor's sleep indication and the busy flags of the fuse, life-cycle and flash blocks. If any of them objects, the entry is aborted. Otherwise clocks are stopped, the resets are asserted, and the block returns to its powered-down state to wait for the slow domain.

A reset request in the active state takes the same way down. It then climbs straight back up through the same chain without any request from the slow domain. Reset requests are the enabled peripheral request inputs plus an escalation input that cannot be masked. A cause output records whether the last way down was a low-power entry or a reset.

Top module: `pwr_fast_seq`

## Requirements
- R1: After rst_ni is released the block is powered down: lc_rst_req_o=1, sys_rst_req_o=1, otp_init_o=0, lc_init_o=0, clk_en_o=0, strap_o=0, pwrup_ack_o=0, lp_abort_o=0, fast_down_o=1 and rst_cause_o=0. It stays in this state until pwrup_req_i is high.
- R2: On power-up the block first drops lc_rst_req_o and fast_down_o, and waits for lc_rst_src_i to go low. It then raises otp_init_o and waits for otp_done_i to be high. After that it raises lc_init_o and waits for lc_done_i to be high.
- R3: After life-cycle init the block raises clk_en_o and waits for clk_status_i to be high. It then drives strap_o high for exactly one cycle.
- R4: After the strap pulse, pwrup_ack_o is high for exactly one cycle. Then sys_rst_req_o drops, and the block becomes active once sys_rst_src_i is low.
- R5: rst_reqs_o[i] equals rst_req_i[i] & rst_en_i[i], one clock later, for i below N_RST_REQ. The top bit rst_reqs_o[N_RST_REQ] follows esc_rst_i one clock later, whatever the enables are.
- R6: Any set bit of rst_reqs_o while active starts a reset path, in this order:
  - clk_en_o drops and rst_cause_o becomes 2;
  - once clk_status_i is low, lc_rst_req_o and sys_rst_req_o go to 1 and otp_init_o and lc_init_o go to 0;
  - once both reset source inputs are high and both done inputs are low, fast_down_o goes to 1;
  - the R2 to R4 chain then restarts without pwrup_req_i.
- R7: While active, sw_lp_req_i with core_sleep_i=1 and no busy input high takes the same way down with rst_cause_o=1. The block then stays powered down until pwrup_req_i is high.
- R8: If core_sleep_i is 0, or any of otp_busy_i, lc_busy_i or flash_busy_i is 1, when a low-power request is checked, lp_abort_o goes high. In that case clk_en_o stays 1 and sys_rst_req_o stays 0. lp_abort_o stays high until sw_lp_req_i is low, and then the block is active again.
- R9: A reset request that arrives together with a low-power request wins. The way down reports rst_cause_o=2 and the chain restarts on its own.
- R10: rst_cause_o keeps its value through power-up, the active state and aborted low-power entries. It changes only when a new way down begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwrup_req_i | input | 1 | Power-up request from slow domain |
| pwrup_ack_o | output | 1 | One-cycle power-up acknowledge to slow domain |
| fast_down_o | output | 1 | Fast side is powered down |
| lc_rst_req_o | output | 1 | Life-cycle reset stage request |
| lc_rst_src_i | input | 1 | Life-cycle reset active, from reset controller |
| sys_rst_req_o | output | 1 | System reset stage request |
| sys_rst_src_i | input | 1 | System reset active, from reset controller |
| otp_init_o | output | 1 | Start fuse sensing |
| otp_done_i | input | 1 | Fuse sensing done |
| lc_init_o | output | 1 | Start life-cycle init |
| lc_done_i | input | 1 | Life-cycle init done |
| clk_en_o | output | 1 | Peripheral clock enable |
| clk_status_i | input | 1 | Peripheral clocks running |
| strap_o | output | 1 | One-cycle strap sample pulse |
| sw_lp_req_i | input | 1 | Software low-power request |
| core_sleep_i | input | 1 | Processor is asleep |
| otp_busy_i | input | 1 | Fuse block busy |
| lc_busy_i | input | 1 | Life-cycle block busy |
| flash_busy_i | input | 1 | Flash busy |
| lp_abort_o | output | 1 | Low-power entry aborted |
| rst_req_i | input | N_RST_REQ | Peripheral reset requests |
| rst_en_i | input | N_RST_REQ | Per-request enables |
| esc_rst_i | input | 1 | Escalation reset, unmaskable |
| rst_reqs_o | output | N_RST_REQ+1 | Registered effective requests, escalation at top bit |
| rst_cause_o | output | 2 | 0 none, 1 low-power, 2 reset request |

## Verification
The hardest case to reach is a reset request and a low-power request landing in the same cycle. The request merge adds a register stage, so the low-power path is already one step ahead when the reset becomes visible. The bench raises escalation and the low-power request on the same falling edge, with the processor asleep. It then expects the way down to report a reset cause and the chain to restart by itself. Aborts are reached by holding the low-power request while either the sleep flag is low or one busy flag is set. The bench then confirms that the clocks and the released resets never moved.

// File: rtl/pwr_fast_pkg.sv
package pwr_fast_pkg;

  typedef enum logic [3:0] {
    ST_LOWPOWER,
    ST_LC_REL,
    ST_OTP_INIT,
    ST_LC_INIT,
    ST_CLK_ON,
    ST_STRAP,
    ST_ACK,
    ST_SYS_REL,
    ST_ACTIVE,
    ST_LP_CHECK,
    ST_LP_ABORT,
    ST_DN_CLK,
    ST_DN_RST
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LOWPOWER = 2'd1,
    CAUSE_RESET    = 2'd2
  } rst_cause_e;

endpackage

// File: rtl/pwr_rst_merge.sv
module pwr_rst_merge #(
  parameter int N_REQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] en_i,
  input  logic             esc_i,
  output logic [N_REQ:0]   reqs_o,
  output logic             any_o
);

  localparam int NW = N_REQ + 1;

  logic [NW-1:0] reqs_d, reqs_q;

  for (genvar g = 0; g < N_REQ; g++) begin : g_mask
    assign reqs_d[g] = req_i[g] & en_i[g];
  end
  assign reqs_d[N_REQ] = esc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reqs_q <= '0;
    else         reqs_q <= reqs_d;
  end

  assign reqs_o = reqs_q;
  assign any_o  = |reqs_q;

  // R5: escalation ignores the enables
  p_esc_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> reqs_o[N_REQ]);

endmodule

// File: rtl/pwr_lp_gate.sv
module pwr_lp_gate #(
  parameter int N_BUSY = 3
) (
  input  logic              core_sleep_i,
  input  logic [N_BUSY-1:0] busy_i,
  output logic              lp_ok_o
);

  assign lp_ok_o = core_sleep_i & ~(|busy_i);

endmodule

// File: rtl/pwr_fast_fsm.sv
module pwr_fast_fsm
  import pwr_fast_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwrup_req_i,
  input  logic       rst_any_i,
  input  logic       lp_req_i,
  input  logic       lp_ok_i,
  input  logic       lc_rst_src_i,
  input  logic       sys_rst_src_i,
  input  logic       otp_done_i,
  input  logic       lc_done_i,
  input  logic       clk_status_i,
  output logic       pwrup_ack_o,
  output logic       fast_down_o,
  output logic       lc_rst_req_o,
  output logic       sys_rst_req_o,
  output logic       otp_init_o,
  output logic       lc_init_o,
  output logic       clk_en_o,
  output logic       strap_o,
  output logic       lp_abort_o,
  output logic [1:0] rst_cause_o
);

  seq_state_e state_q, state_d;
  rst_cause_e cause_q, cause_d;
  logic       loop_q, loop_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOWPOWER;
      cause_q <= CAUSE_NONE;
      loop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      loop_q  <= loop_d;
    end
  end

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    loop_d  = loop_q;
    unique case (state_q)
      ST_LOWPOWER: if (pwrup_req_i || loop_q) begin
        state_d = ST_LC_REL;
        loop_d  = 1'b0;
      end
      ST_LC_REL:   if (!lc_rst_src_i)  state_d = ST_OTP_INIT;
      ST_OTP_INIT: if (otp_done_i)     state_d = ST_LC_INIT;
      ST_LC_INIT:  if (lc_done_i)      state_d = ST_CLK_ON;
      ST_CLK_ON:   if (clk_status_i)   state_d = ST_STRAP;
      ST_STRAP:                        state_d = ST_ACK;
      ST_ACK:                          state_d = ST_SYS_REL;
      ST_SYS_REL:  if (!sys_rst_src_i) state_d = ST_ACTIVE;
      ST_ACTIVE, ST_LP_CHECK, ST_LP_ABORT: begin
        // reset requests win over any low-power progress
        if (rst_any_i) begin
          state_d = ST_DN_CLK;
          cause_d = CAUSE_RESET;
          loop_d  = 1'b1;
        end else if (state_q == ST_ACTIVE) begin
          if (lp_req_i) state_d = ST_LP_CHECK;
        end else if (state_q == ST_LP_CHECK) begin
          if (lp_ok_i) begin
            state_d = ST_DN_CLK;
            cause_d = CAUSE_LOWPOWER;
          end else begin
            state_d = ST_LP_ABORT;
          end
        end else if (!lp_req_i) begin
          state_d = ST_ACTIVE;
        end
      end
      ST_DN_CLK:   if (!clk_status_i) state_d = ST_DN_RST;
      ST_DN_RST:   if (lc_rst_src_i && sys_rst_src_i && !otp_done_i && !lc_done_i)
                     state_d = ST_LOWPOWER;
      default:     state_d = ST_LOWPOWER;
    endcase
  end

  always_comb begin
    lc_rst_req_o  = 1'b0;
    sys_rst_req_o = 1'b0;
    otp_init_o    = 1'b1;
    lc_init_o     = 1'b1;
    clk_en_o      = 1'b0;
    strap_o       = 1'b0;
    pwrup_ack_o   = 1'b0;
    lp_abort_o    = 1'b0;
    fast_down_o   = 1'b0;
    unique case (state_q)
      ST_LOWPOWER, ST_DN_RST: begin
        lc_rst_req_o  = 1'b1;
        sys_rst_req_o = 1'b1;
        otp_init_o    = 1'b0;
        lc_init_o     = 1'b0;
        fast_down_o   = (state_q == ST_LOWPOWER);
      end
      ST_LC_REL: begin
        sys_rst_req_o = 1'b1;
        otp_init_o    = 1'b0;
        lc_init_o     = 1'b0;
      end
      ST_OTP_INIT: begin
        sys_rst_req_o = 1'b1;
        lc_init_o     = 1'b0;
      end
      ST_LC_INIT:  sys_rst_req_o = 1'b1;
      ST_CLK_ON: begin
        sys_rst_req_o = 1'b1;
        clk_en_o      = 1'b1;
      end
      ST_STRAP: begin
        sys_rst_req_o = 1'b1;
        clk_en_o      = 1'b1;
        strap_o       = 1'b1;
      end
      ST_ACK: begin
        sys_rst_req_o = 1'b1;
        clk_en_o      = 1'b1;
        pwrup_ack_o   = 1'b1;
      end
      ST_SYS_REL, ST_ACTIVE, ST_LP_CHECK: clk_en_o = 1'b1;
      ST_LP_ABORT: begin
        clk_en_o   = 1'b1;
        lp_abort_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign rst_cause_o = cause_q;

  p_lc_init_after_otp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lc_init_o) |-> $past(otp_done_i));

  p_otp_after_lc_rel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(otp_init_o) |-> (!lc_rst_req_o && $past(!lc_rst_src_i)));

  p_strap_after_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strap_o) |-> $past(clk_status_i));

  p_ack_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrup_ack_o |=> !pwrup_ack_o);

  p_sys_rel_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_req_o) |-> $past(pwrup_ack_o));

  p_rst_after_clk_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> (!clk_en_o && $past(!clk_status_i)));

  p_abort_reason_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_abort_o) |-> $past(!lp_ok_i));

  p_cause_only_on_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_cause_o) |-> !clk_en_o);

endmodule

// File: rtl/pwr_fast_seq.sv
module pwr_fast_seq #(
  parameter int N_RST_REQ = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwrup_req_i,
  output logic                 pwrup_ack_o,
  output logic                 fast_down_o,
  output logic                 lc_rst_req_o,
  input  logic                 lc_rst_src_i,
  output logic                 sys_rst_req_o,
  input  logic                 sys_rst_src_i,
  output logic                 otp_init_o,
  input  logic                 otp_done_i,
  output logic                 lc_init_o,
  input  logic                 lc_done_i,
  output logic                 clk_en_o,
  input  logic                 clk_status_i,
  output logic                 strap_o,
  input  logic                 sw_lp_req_i,
  input  logic                 core_sleep_i,
  input  logic                 otp_busy_i,
  input  logic                 lc_busy_i,
  input  logic                 flash_busy_i,
  output logic                 lp_abort_o,
  input  logic [N_RST_REQ-1:0] rst_req_i,
  input  logic [N_RST_REQ-1:0] rst_en_i,
  input  logic                 esc_rst_i,
  output logic [N_RST_REQ:0]   rst_reqs_o,
  output logic [1:0]           rst_cause_o
);

  localparam int N_BUSY = 3;

  logic              rst_any;
  logic              lp_ok;
  logic [N_BUSY-1:0] busy;

  assign busy = {flash_busy_i, lc_busy_i, otp_busy_i};

  pwr_rst_merge #(.N_REQ(N_RST_REQ)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rst_req_i),
    .en_i   (rst_en_i),
    .esc_i  (esc_rst_i),
    .reqs_o (rst_reqs_o),
    .any_o  (rst_any)
  );

  pwr_lp_gate #(.N_BUSY(N_BUSY)) u_gate (
    .core_sleep_i (core_sleep_i),
    .busy_i       (busy),
    .lp_ok_o      (lp_ok)
  );

  pwr_fast_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwrup_req_i   (pwrup_req_i),
    .rst_any_i     (rst_any),
    .lp_req_i      (sw_lp_req_i),
    .lp_ok_i       (lp_ok),
    .lc_rst_src_i  (lc_rst_src_i),
    .sys_rst_src_i (sys_rst_src_i),
    .otp_done_i    (otp_done_i),
    .lc_done_i     (lc_done_i),
    .clk_status_i  (clk_status_i),
    .pwrup_ack_o   (pwrup_ack_o),
    .fast_down_o   (fast_down_o),
    .lc_rst_req_o  (lc_rst_req_o),
    .sys_rst_req_o (sys_rst_req_o),
    .otp_init_o    (otp_init_o),
    .lc_init_o     (lc_init_o),
    .clk_en_o      (clk_en_o),
    .strap_o       (strap_o),
    .lp_abort_o    (lp_abort_o),
    .rst_cause_o   (rst_cause_o)
  );

endmodule

// File: tb/pwr_fast_seq_bench.sv
module pwr_fast_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  typedef struct packed {
    logic       lc;
    logic       sys;
    logic       otp;
    logic       lci;
    logic       clk;
    logic       strap;
    logic       ack;
    logic       abrt;
    logic       dn;
    logic [1:0] cause;
  } snap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrup_req = 1'b0, sw_lp_req = 1'b0, core_sleep = 1'b0;
  logic otp_busy = 1'b0, lc_busy = 1'b0, flash_busy = 1'b0, esc = 1'b0;
  logic [NR-1:0] rq = '0, en = '0;
  logic lc_src = 1'b1, sys_src = 1'b1, otp_done = 1'b0, lc_done = 1'b0, clk_st = 1'b0;
  logic pwrup_ack, fast_down, lc_req, sys_req, otp_init, lc_init, clk_en, strap, lp_abort;
  logic [NR:0] reqs;
  logic [1:0] cause;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  snap_t exp_q[$];
  string tag_q[$];
  snap_t e;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fast_seq #(.N_RST_REQ(NR)) u_pwr_fast_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwrup_req_i(pwrup_req), .pwrup_ack_o(pwrup_ack),
    .fast_down_o(fast_down), .lc_rst_req_o(lc_req), .lc_rst_src_i(lc_src),
    .sys_rst_req_o(sys_req), .sys_rst_src_i(sys_src), .otp_init_o(otp_init),
    .otp_done_i(otp_done), .lc_init_o(lc_init), .lc_done_i(lc_done),
    .clk_en_o(clk_en), .clk_status_i(clk_st), .strap_o(strap),
    .sw_lp_req_i(sw_lp_req), .core_sleep_i(core_sleep), .otp_busy_i(otp_busy),
    .lc_busy_i(lc_busy), .flash_busy_i(flash_busy), .lp_abort_o(lp_abort),
    .rst_req_i(rq), .rst_en_i(en), .esc_rst_i(esc), .rst_reqs_o(reqs),
    .rst_cause_o(cause)
  );

  // neighbour responders: each follows its request after a short delay
  initial begin
    logic [1:0] lcp, sysp, clkp;
    logic [2:0] otpp;
    logic [1:0] lcdp;
    lcp = 2'b11; sysp = 2'b11; clkp = 2'b00; otpp = 3'b000; lcdp = 2'b00;
    forever begin
      @(negedge clk);
      lcp  = {lcp[0], lc_req};
      sysp = {sysp[0], sys_req};
      clkp = {clkp[0], clk_en};
      otpp = {otpp[1:0], otp_init};
      lcdp = {lcdp[0], lc_init};
      lc_src = lcp[1]; sys_src = sysp[1]; clk_st = clkp[1];
      otp_done = otpp[2]; lc_done = lcdp[1];
    end
  end

  function automatic snap_t cur_snap();
    snap_t s;
    s = '{lc: lc_req, sys: sys_req, otp: otp_init, lci: lc_init, clk: clk_en,
          strap: strap, ack: pwrup_ack, abrt: lp_abort, dn: fast_down, cause: cause};
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push(input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: every change of the output snapshot pops one expectation
  initial begin
    snap_t last, now, want;
    string t;
    @(posedge rst_n);
    @(negedge clk);
    last = cur_snap();
    forever begin
      @(negedge clk);
      now = cur_snap();
      if (now != last) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected output change", 16'(now), 16'(last));
        end else begin
          want = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(now == want, t, "snapshot", 16'(now), 16'(want));
        end
        last = now;
      end
    end
  end

  task automatic exp_up();
    e.lc = 0; e.dn = 0;            push("R2 lc reset released");
    e.otp = 1;                     push("R2 otp init");
    e.lci = 1;                     push("R2 lc init");
    e.clk = 1;                     push("R3 clocks on");
    e.strap = 1;                   push("R3 strap pulse");
    e.strap = 0; e.ack = 1;        push("R4 ack pulse");
    e.ack = 0; e.sys = 0;          push("R4 sys reset released");
  endtask

  task automatic exp_down(input logic [1:0] c, input string req);
    e.clk = 0; e.cause = c;        push(req);
    e.lc = 1; e.sys = 1; e.otp = 0; e.lci = 0; push(req);
    e.dn = 1;                      push(req);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, req, "sequence completed", 16'(exp_q.size()), 16'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    e = '{lc: 1, sys: 1, otp: 0, lci: 0, clk: 0, strap: 0, ack: 0, abrt: 0, dn: 1, cause: 2'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cur_snap() == e, "R1", "reset state", 16'(cur_snap()), 16'(e));

    // R5 merge, while powered down (no state effect expected)
    en = 4'b0101; rq = 4'b0011;
    repeat (2) @(negedge clk);
    chk(reqs == 5'b00001, "R5", "masked requests", 16'(reqs), 16'h01);
    en = 4'b0000; esc = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqs == 5'b10000, "R5", "escalation unmasked", 16'(reqs), 16'h10);
    esc = 1'b0; rq = '0;
    repeat (20) @(negedge clk);
    chk(fast_down == 1'b1, "R1", "waits for power-up request", 16'(fast_down), 16'd1);

    // R2-R4 power-up
    exp_up();
    pwrup_req = 1'b1;
    drain("R4");
    pwrup_req = 1'b0;

    // R8 abort: processor awake
    core_sleep = 1'b0; sw_lp_req = 1'b1;
    e.abrt = 1; push("R8 abort awake");
    drain("R8");
    chk(clk_en && !sys_req, "R8", "clk on, reset released", {14'd0, clk_en, sys_req}, 16'h2);
    chk(cause == 2'd0, "R10", "cause kept after abort", 16'(cause), 16'd0);
    e.abrt = 0; push("R8 abort released");
    sw_lp_req = 1'b0;
    drain("R8");

    // R8 abort: flash busy
    core_sleep = 1'b1; flash_busy = 1'b1; sw_lp_req = 1'b1;
    e.abrt = 1; push("R8 abort busy");
    drain("R8");
    e.abrt = 0; push("R8 abort busy released");
    sw_lp_req = 1'b0; flash_busy = 1'b0;
    drain("R8");

    // R7 low-power entry
    core_sleep = 1'b1; sw_lp_req = 1'b1;
    exp_down(2'd1, "R7 low-power down");
    drain("R7");
    sw_lp_req = 1'b0; core_sleep = 1'b0;
    repeat (30) @(negedge clk);
    chk(fast_down == 1'b1, "R7", "stays down without request", 16'(fast_down), 16'd1);
    chk(cause == 2'd1, "R7", "cause low-power", 16'(cause), 16'd1);
    exp_up();
    pwrup_req = 1'b1;
    drain("R7");
    pwrup_req = 1'b0;
    chk(cause == 2'd1, "R10", "cause kept through power-up", 16'(cause), 16'd1);

    // R5 masked peripheral requests while active: no effect
    rq = '1; en = '0;
    repeat (10) @(negedge clk);
    chk(reqs == '0 && !fast_down, "R5", "masked requests ignored", 16'(reqs), 16'd0);
    rq = '0;

    // R6 enabled peripheral request loops back without slow domain
    en = 4'b0100;
    exp_down(2'd2, "R6 reset down");
    exp_up();
    rq = 4'b0100;
    repeat (3) @(negedge clk);
    rq = '0;
    drain("R6");
    chk(cause == 2'd2 && !fast_down, "R6", "auto restart, cause reset",
        {14'd0, cause}, 16'd2);

    // R9 reset and low-power together
    en = '0;
    core_sleep = 1'b1;
    exp_down(2'd2, "R9 reset wins");
    exp_up();
    sw_lp_req = 1'b1; esc = 1'b1;
    repeat (3) @(negedge clk);
    sw_lp_req = 1'b0; esc = 1'b0; core_sleep = 1'b0;
    drain("R9");
    chk(cause == 2'd2, "R9", "cause reset", 16'(cause), 16'd2);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "no stray changes", 16'(exp_q.size()), 16'd0);
    finish_run();
  end

endmodule